// File: doc/BRIEF.md
# Wrap-Aware Command Fetch Splitter

This block moves pending fixed-size command packets from a circular queue in host memory into a smaller circular packet buffer on the device. Software advances the host write index. When that index differs from the block's own host read index, the block claims slots in the local ring and issues DMA read requests that fill those slots. The local ring hands out at most as many slots as are free. Each DMA request is sized so that it never runs past the end of the host ring or of the local ring. The block then counts the packets that the DMA engine reports as delivered. When the whole series has arrived, it pulses a request to start packet processing.

The DMA engine and the packet storage sit outside the block. The block keeps the local ring's write position and free-slot count, and the consumer returns retired slots through a free input. If the local ring could not take every pending packet, a stall flag stays set. The next fetch attempt is made only after slots have been returned. Packets are 64 bytes by default. A request carries the byte address `host_base + position*64` and a byte length of `count*64`.

The control is a three-state machine. IDLE waits for pending packets. The transition IDLE→ISSUE is taken when a slot grant is non-zero. In ISSUE the block presents one chunk request at a time. The transition ISSUE→DRAIN is taken when the chunk that uses up the grant is accepted. DRAIN waits for the completions, and the transition DRAIN→IDLE is taken once none are outstanding. A zero grant keeps the machine in IDLE and sets the stall flag.

Top module: `cmd_fetch_splitter`

## Requirements
- R1: The pending count is `host_wr_idx - host_rd_idx`, taken modulo 2^(log2(HQ_DEPTH)+1). When it is zero, no DMA request is raised.
- R2: No new fetch series starts while `busy` is high. `busy` is high from the series start until the last completion, and a DMA request is only ever raised while `busy` is high.
- R3: The slot grant is min(pending, free local slots). `host_rd_idx` advances by exactly the grant, on the clock edge that starts the series.
- R4: The first chunk of a series targets the local slot equal to the local write position before the grant. That position is the local write position after the grant minus the grant, modulo LQ_DEPTH.
- R5: Each chunk count is the minimum of four values: host entries before the host ring wraps, local entries before the local ring wraps, packets remaining and grant remaining. The count is never zero.
- R6: `dma_req_addr` equals `host_base + host_position*64` and `dma_req_bytes` equals `dma_req_cnt*64`.
- R7: After each accepted chunk, the host position advances modulo HQ_DEPTH and the local slot advances modulo LQ_DEPTH, each by the chunk count.
- R8: `stalled` is set at a series attempt whose grant is smaller than the pending count, and this includes a grant of zero. It clears at an attempt whose grant covers everything pending. While it is set, an attempt is made only once free slots exist again.
- R9: Each `dma_done_valid` subtracts `dma_done_cnt` from the series total. The completion that brings the total to zero clears `busy` and pulses `proc_start` high for exactly one cycle, on the clock edge that samples it.
- R10: While `dma_req_valid` is high and `dma_req_ready` is low, the request fields stay unchanged.
- R11: After reset, `dma_req_valid`, `busy`, `stalled` and `proc_start` are low, `host_rd_idx` is 0 and all LQ_DEPTH local slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_base | input | ADDR_W | Byte base address of the host ring |
| host_wr_idx | input | HIW | Host write index, free-running |
| free_valid | input | 1 | Local slots are being returned this cycle |
| free_cnt | input | CW | Number of local slots returned |
| dma_req_valid | output | 1 | Chunk request present |
| dma_req_ready | input | 1 | DMA engine accepts the chunk this cycle |
| dma_req_addr | output | ADDR_W | Host byte address of the chunk |
| dma_req_bytes | output | BW | Byte length of the chunk |
| dma_req_slot | output | LPW | First local slot written by the chunk |
| dma_req_cnt | output | CW | Packets in the chunk |
| dma_done_valid | input | 1 | A chunk has landed |
| dma_done_cnt | input | CW | Packets in the landed chunk |
| proc_start | output | 1 | One-cycle pulse to start processing |
| busy | output | 1 | A fetch series is outstanding |
| stalled | output | 1 | The local ring ran out of space |
| host_rd_idx | output | HIW | Host read index, free-running |

## Verification
The block starts a series on the first clock edge at which it is idle and has pending packets. On that edge `host_rd_idx`, `stalled` and `busy` take their new values, and the first chunk request is visible just after it. A returned slot is counted on the edge that samples it, and a stalled retry starts one edge later. `proc_start` rises on the edge that samples the final completion. The bench drives inputs just after a rising edge and samples outputs on the falling edge. Its reference model computes the chunk list when the stimulus is applied, and each request is compared on the falling edge before the edge that accepts it.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ISSUE = 2'd1,
        FS_DRAIN = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/cfs_slot_alloc.sv
module cfs_slot_alloc #(
    parameter  int LQ_DEPTH = 8,
    parameter  int CW       = 5,
    localparam int LPW      = $clog2(LQ_DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [CW-1:0]  req_cnt,
    input  logic           free_valid,
    input  logic [CW-1:0]  free_cnt,
    output logic [CW-1:0]  grant_cnt,
    output logic [LPW-1:0] first_slot,
    output logic [CW-1:0]  free_slots
);

    logic [LPW-1:0] wr_pos;

    // grant is capped by the free count; no request yields no grant
    always_comb begin
        if (!req_valid)
            grant_cnt = '0;
        else if (req_cnt > free_slots)
            grant_cnt = free_slots;
        else
            grant_cnt = req_cnt;
    end

    assign first_slot = wr_pos;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_slots <= CW'(LQ_DEPTH);
            wr_pos     <= '0;
        end else begin
            free_slots <= free_slots - grant_cnt + (free_valid ? free_cnt : '0);
            wr_pos     <= wr_pos + grant_cnt[LPW-1:0];
        end
    end

endmodule

// File: rtl/cfs_chunk_size.sv
module cfs_chunk_size #(
    parameter  int HQ_DEPTH = 16,
    parameter  int LQ_DEPTH = 8,
    parameter  int CW       = 5,
    localparam int HPW      = $clog2(HQ_DEPTH),
    localparam int LPW      = $clog2(LQ_DEPTH)
) (
    input  logic [HPW-1:0] host_pos,
    input  logic [LPW-1:0] loc_pos,
    input  logic [CW-1:0]  remain,
    input  logic [CW-1:0]  grant_left,
    output logic [CW-1:0]  chunk
);

    logic [CW-1:0] host_room;
    logic [CW-1:0] loc_room;
    logic [CW-1:0] ring_lim;
    logic [CW-1:0] work_lim;

    always_comb begin
        host_room = CW'(HQ_DEPTH) - CW'(host_pos);
        loc_room  = CW'(LQ_DEPTH) - CW'(loc_pos);
        ring_lim  = (host_room < loc_room) ? host_room : loc_room;
        work_lim  = (remain < grant_left) ? remain : grant_left;
        chunk     = (ring_lim < work_lim) ? ring_lim : work_lim;
    end

endmodule

// File: rtl/cfs_done_tracker.sv
module cfs_done_tracker #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_valid,
    input  logic [CW-1:0] load_cnt,
    input  logic          done_valid,
    input  logic [CW-1:0] done_cnt,
    output logic          busy,
    output logic          proc_start
);

    logic [CW-1:0] outstanding;
    logic          last_done;

    assign busy      = (outstanding != '0);
    assign last_done = done_valid && busy && (done_cnt >= outstanding);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= '0;
            proc_start  <= 1'b0;
        end else begin
            proc_start <= last_done;
            if (load_valid)
                outstanding <= load_cnt;
            else if (last_done)
                outstanding <= '0;
            else if (done_valid && busy)
                outstanding <= outstanding - done_cnt;
        end
    end

endmodule

// File: rtl/cmd_fetch_splitter.sv
module cmd_fetch_splitter
    import cfs_pkg::*;
#(
    parameter  int ADDR_W    = 32,
    parameter  int HQ_DEPTH  = 16,
    parameter  int LQ_DEPTH  = 8,
    parameter  int PKT_BYTES = 64,
    localparam int HPW       = $clog2(HQ_DEPTH),
    localparam int HIW       = HPW + 1,
    localparam int LPW       = $clog2(LQ_DEPTH),
    localparam int MAXD      = (HQ_DEPTH > LQ_DEPTH) ? HQ_DEPTH : LQ_DEPTH,
    localparam int CW        = $clog2(MAXD) + 1,
    localparam int PSH       = $clog2(PKT_BYTES),
    localparam int BW        = CW + PSH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_base,
    input  logic [HIW-1:0]    host_wr_idx,
    input  logic              free_valid,
    input  logic [CW-1:0]     free_cnt,
    output logic              dma_req_valid,
    input  logic              dma_req_ready,
    output logic [ADDR_W-1:0] dma_req_addr,
    output logic [BW-1:0]     dma_req_bytes,
    output logic [LPW-1:0]    dma_req_slot,
    output logic [CW-1:0]     dma_req_cnt,
    input  logic              dma_done_valid,
    input  logic [CW-1:0]     dma_done_cnt,
    output logic              proc_start,
    output logic              busy,
    output logic              stalled,
    output logic [HIW-1:0]    host_rd_idx
);

    fetch_state_e   state_q;
    fetch_state_e   state_d;

    logic [HIW-1:0] rd_idx;
    logic [HPW-1:0] host_pos;
    logic [LPW-1:0] loc_pos;
    logic [CW-1:0]  remain;
    logic [CW-1:0]  grant_left;

    logic [HIW-1:0] pending;
    logic [CW-1:0]  pending_c;
    logic           start_ok;
    logic           series_go;
    logic           chunk_take;
    logic [CW-1:0]  grant;
    logic [LPW-1:0] first_slot;
    logic [CW-1:0]  free_slots;
    logic [CW-1:0]  chunk;

    // pending packets from the free-running indices
    assign pending    = host_wr_idx - rd_idx;
    assign pending_c  = CW'(pending);
    assign start_ok   = (state_q == FS_IDLE) && !busy && (pending_c != '0) &&
                        (!stalled || (free_slots != '0));
    assign series_go  = start_ok && (grant != '0);
    assign chunk_take = (state_q == FS_ISSUE) && dma_req_ready;

    cfs_slot_alloc #(
        .LQ_DEPTH (LQ_DEPTH),
        .CW       (CW)
    ) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (start_ok),
        .req_cnt    (pending_c),
        .free_valid (free_valid),
        .free_cnt   (free_cnt),
        .grant_cnt  (grant),
        .first_slot (first_slot),
        .free_slots (free_slots)
    );

    cfs_chunk_size #(
        .HQ_DEPTH (HQ_DEPTH),
        .LQ_DEPTH (LQ_DEPTH),
        .CW       (CW)
    ) u_chunk (
        .host_pos   (host_pos),
        .loc_pos    (loc_pos),
        .remain     (remain),
        .grant_left (grant_left),
        .chunk      (chunk)
    );

    cfs_done_tracker #(
        .CW (CW)
    ) u_done (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (series_go),
        .load_cnt   (grant),
        .done_valid (dma_done_valid),
        .done_cnt   (dma_done_cnt),
        .busy       (busy),
        .proc_start (proc_start)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:  if (series_go) state_d = FS_ISSUE;
            FS_ISSUE: if (chunk_take && (grant_left == chunk)) state_d = FS_DRAIN;
            FS_DRAIN: if (!busy) state_d = FS_IDLE;
            default:  state_d = FS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FS_IDLE;
        else
            state_q <= state_d;
    end

    // series and chunk bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx     <= '0;
            host_pos   <= '0;
            loc_pos    <= '0;
            remain     <= '0;
            grant_left <= '0;
            stalled    <= 1'b0;
        end else begin
            if (start_ok)
                stalled <= (grant < pending_c);
            if (series_go) begin
                rd_idx     <= rd_idx + HIW'(grant);
                host_pos   <= rd_idx[HPW-1:0];
                loc_pos    <= first_slot;
                remain     <= pending_c;
                grant_left <= grant;
            end else if (chunk_take) begin
                host_pos   <= host_pos + chunk[HPW-1:0];
                loc_pos    <= loc_pos + chunk[LPW-1:0];
                remain     <= remain - chunk;
                grant_left <= grant_left - chunk;
            end
        end
    end

    // request outputs
    always_comb begin
        dma_req_valid = (state_q == FS_ISSUE);
        dma_req_addr  = host_base + (ADDR_W'(host_pos) << PSH);
        dma_req_bytes = BW'(chunk) << PSH;
        dma_req_slot  = loc_pos;
        dma_req_cnt   = chunk;
    end

    assign host_rd_idx = rd_idx;

endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
    parameter int ADDR_W   = 32,
    parameter int LQ_DEPTH = 8,
    parameter int HIW      = 5,
    parameter int LPW      = 3,
    parameter int CW       = 5,
    parameter int BW       = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_req_valid,
    input logic              dma_req_ready,
    input logic [ADDR_W-1:0] dma_req_addr,
    input logic [BW-1:0]     dma_req_bytes,
    input logic [LPW-1:0]    dma_req_slot,
    input logic [CW-1:0]     dma_req_cnt,
    input logic              proc_start,
    input logic              busy,
    input logic [HIW-1:0]    host_rd_idx
);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_valid && !dma_req_ready) |=> (dma_req_valid && $stable(dma_req_addr) &&
            $stable(dma_req_bytes) && $stable(dma_req_slot) && $stable(dma_req_cnt)));

    assert_no_local_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_valid |-> ((dma_req_cnt != '0) &&
            (int'(dma_req_slot) + int'(dma_req_cnt) <= LQ_DEPTH)));

    assert_req_in_series_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_valid |-> busy);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proc_start |=> !proc_start);

    assert_idle_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proc_start |-> !busy);

    assert_rd_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_idx != $past(host_rd_idx)) |-> (busy && !$past(busy)));

endmodule

bind cmd_fetch_splitter cfs_checker #(
    .ADDR_W   (ADDR_W),
    .LQ_DEPTH (LQ_DEPTH),
    .HIW      (HIW),
    .LPW      (LPW),
    .CW       (CW),
    .BW       (BW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dma_req_valid (dma_req_valid),
    .dma_req_ready (dma_req_ready),
    .dma_req_addr  (dma_req_addr),
    .dma_req_bytes (dma_req_bytes),
    .dma_req_slot  (dma_req_slot),
    .dma_req_cnt   (dma_req_cnt),
    .proc_start    (proc_start),
    .busy          (busy),
    .host_rd_idx   (host_rd_idx)
);

// File: tb/cmd_fetch_splitter_bench.sv
module cmd_fetch_splitter_bench;

    localparam int AW  = 32;
    localparam int HQ  = 16;
    localparam int LQ  = 8;
    localparam int HIW = 5;
    localparam int LPW = 3;
    localparam int CW  = 5;
    localparam int BW  = 11;
    localparam logic [AW-1:0] BASE = 32'h8000_1000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  host_base = BASE;
    logic [HIW-1:0] host_wr_idx = '0;
    logic           free_valid = 1'b0;
    logic [CW-1:0]  free_cnt = '0;
    logic           dma_req_valid;
    logic           dma_req_ready = 1'b1;
    logic [AW-1:0]  dma_req_addr;
    logic [BW-1:0]  dma_req_bytes;
    logic [LPW-1:0] dma_req_slot;
    logic [CW-1:0]  dma_req_cnt;
    logic           dma_done_valid = 1'b0;
    logic [CW-1:0]  dma_done_cnt = '0;
    logic           proc_start;
    logic           busy;
    logic           stalled;
    logic [HIW-1:0] host_rd_idx;

    always #2 clk = ~clk;

    cmd_fetch_splitter u_cmd_fetch_splitter (
        .clk(clk), .rst_n(rst_n), .host_base(host_base), .host_wr_idx(host_wr_idx),
        .free_valid(free_valid), .free_cnt(free_cnt),
        .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
        .dma_req_addr(dma_req_addr), .dma_req_bytes(dma_req_bytes),
        .dma_req_slot(dma_req_slot), .dma_req_cnt(dma_req_cnt),
        .dma_done_valid(dma_done_valid), .dma_done_cnt(dma_done_cnt),
        .proc_start(proc_start), .busy(busy), .stalled(stalled), .host_rd_idx(host_rd_idx)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // reference model state
    int m_wr = 0, m_rd = 0, m_lwr = 0, m_free = LQ;
    bit m_stall = 0;
    int eq_addr[$], eq_slot[$], eq_cnt[$], eq_first[$], dq[$];

    task automatic chk(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int min2(int a, int b);
        return (a < b) ? a : b;
    endfunction

    // behavioural prediction of one fetch attempt
    task automatic model_fetch();
        int pend = (m_wr - m_rd) & 31;
        int g    = min2(pend, m_free);
        int hp, lp, rem, gl, c;
        m_stall = (g < pend);
        if (g == 0) return;
        hp = m_rd % HQ;
        lp = m_lwr;
        m_rd   = (m_rd + g) & 31;
        m_lwr  = (m_lwr + g) % LQ;
        m_free = m_free - g;
        rem = pend;
        gl  = g;
        while (gl > 0) begin
            c = min2(min2(HQ - hp, LQ - lp), min2(rem, gl));
            eq_addr.push_back(int'(BASE) + hp * 64);
            eq_slot.push_back(lp);
            eq_cnt.push_back(c);
            eq_first.push_back(gl == g);
            dq.push_back(c);
            hp = (hp + c) % HQ;
            lp = (lp + c) % LQ;
            rem -= c;
            gl  -= c;
        end
    endtask

    // request monitor, compared on every falling edge
    logic           hold_q = 1'b0;
    logic [AW-1:0]  hold_addr;
    logic [LPW-1:0] hold_slot;
    logic [CW-1:0]  hold_cnt;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_q) begin
                chk("R10", "held addr", dma_req_addr, hold_addr);
                chk("R10", "held cnt", dma_req_cnt, hold_cnt);
                chk("R10", "held slot", dma_req_slot, hold_slot);
            end
            if (dma_req_valid && dma_req_ready) begin
                if (eq_cnt.size() == 0) begin
                    chk("R2", "request outside expected series", 1, 0);
                end else begin
                    chk("R6", "request addr", dma_req_addr, eq_addr[0] & 32'hFFFF_FFFF);
                    chk("R6", "request bytes", dma_req_bytes, eq_cnt[0] * 64);
                    chk(eq_first[0] ? "R4" : "R7", "request slot", dma_req_slot, eq_slot[0]);
                    chk("R5", "request count", dma_req_cnt, eq_cnt[0]);
                    void'(eq_addr.pop_front());
                    void'(eq_slot.pop_front());
                    void'(eq_cnt.pop_front());
                    void'(eq_first.pop_front());
                end
            end
            hold_q    = dma_req_valid && !dma_req_ready;
            hold_addr = dma_req_addr;
            hold_slot = dma_req_slot;
            hold_cnt  = dma_req_cnt;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual %0d cycles expected below 50000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic drain(bit toggle);
        while (eq_cnt.size() != 0) begin
            step();
            if (toggle) dma_req_ready = ~dma_req_ready;
        end
        dma_req_ready = 1'b1;
        step();
        @(negedge clk);
        chk("R2", "busy after issue", busy, 1);
        chk("R8", "stall flag", stalled, m_stall);
        chk("R3", "host read index", host_rd_idx, m_rd);
    endtask

    task automatic finish_series();
        foreach (dq[i]) begin
            step();
            dma_done_valid = 1'b1;
            dma_done_cnt   = CW'(dq[i]);
            @(negedge clk);
            chk("R9", "no early start pulse", proc_start, 0);
        end
        step();
        dma_done_valid = 1'b0;
        @(negedge clk);
        chk("R9", "start pulse after last completion", proc_start, 1);
        chk("R9", "busy cleared", busy, 0);
        @(negedge clk);
        chk("R9", "start pulse one cycle", proc_start, 0);
        dq.delete();
    endtask

    task automatic give_free(int k);
        step();
        free_valid = 1'b1;
        free_cnt   = CW'(k);
        step();
        free_valid = 1'b0;
        m_free += k;
    endtask

    task automatic set_wr(int v);
        step();
        host_wr_idx = HIW'(v);
        m_wr = v & 31;
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "reset req valid", dma_req_valid, 0);
        chk("R11", "reset busy", busy, 0);
        chk("R11", "reset stalled", stalled, 0);
        chk("R11", "reset start pulse", proc_start, 0);
        chk("R11", "reset read index", host_rd_idx, 0);

        // plain fetch of three packets
        set_wr(3); model_fetch(); drain(0); finish_series();

        // more pending than free: local wrap split, then stall
        give_free(3);
        set_wr(12); model_fetch(); drain(0); finish_series();
        repeat (4) step();
        @(negedge clk);
        chk("R8", "stays stalled without free slots", stalled, 1);
        chk("R3", "read index held while stalled", host_rd_idx, 11);
        chk("R2", "idle while stalled", busy, 0);
        give_free(8); model_fetch(); drain(0); finish_series();
        chk("R8", "stall cleared by full grant", stalled, 0);

        // host wrap with back-pressure, doorbell moves while in flight
        give_free(1);
        set_wr(19); model_fetch(); drain(1);
        set_wr(22);
        repeat (3) step();
        @(negedge clk);
        chk("R2", "series still outstanding", busy, 1);
        chk("R3", "read index frozen in flight", host_rd_idx, 19);
        finish_series();
        model_fetch(); drain(0); finish_series();

        // zero free slots: no grant, retry after a free
        repeat (3) step();
        @(negedge clk);
        chk("R8", "stalled with zero grant", stalled, 1);
        chk("R1", "no request while stalled", dma_req_valid, 0);
        give_free(8); model_fetch(); drain(0); finish_series();

        // nothing pending
        repeat (5) step();
        @(negedge clk);
        chk("R1", "no request with zero pending", dma_req_valid, 0);
        chk("R1", "idle with zero pending", busy, 0);

        // index counters wrap, a full host ring pending
        give_free(2);
        set_wr(38); model_fetch(); drain(1); finish_series();
        give_free(8); model_fetch(); drain(0); finish_series();
        chk("R3", "read index after wrap", host_rd_idx, 6);
        chk("R7", "all expected chunks seen", eq_cnt.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule